// File: doc/BRIEF.md
# SCL Minimum-Time and Timeout Timer

This block measures how long the SCL line of a bit-level I2C engine has stayed in its current level. Each SCL transition, reported by a one-clock strobe, restarts a machine-cycle counter at a preset start value. The counter then advances once per machine cycle of six clocks. When it reaches a fixed mark of 8, a flag tells the protocol engine that the minimum high or low time has passed and it may drive the next edge.

The start value is 8 minus a cycle count taken from a two-bit timing select. Because of this, one fixed compare works for every speed setting. If no transition arrives, the same counter keeps running past its 10-bit top value and wraps. The wrap raises a sticky timeout flag and a single-cycle timeout pulse, which together report a stuck bus. A run control stops the timer and clears it. A clear strobe drops the timeout flag.

Top module: `sclt_timer`

## Requirements
- R1: After reset, minDone, ovfFlag and toPulse are all 0.
- R2: While runEn is 1, minDone rises exactly 6*n clock cycles after the cycle in which sclEdge is sampled high, and falls in the cycle after that sclEdge.
- R3: The timing select maps to n as follows: tSel 0 gives n=1, tSel 1 gives n=4, tSel 2 gives n=7 and tSel 3 gives n=10. The counter is loaded with 8-n.
- R4: With runEn held at 1 and no further sclEdge, toPulse comes exactly 6*(1016+n) clock cycles after the sclEdge. This is the wrap of the 10-bit counter past 1023.
- R5: ovfFlag is set by the wrap and stays set until ovfClr is sampled high. If ovfClr and the wrap fall in the same cycle, the flag stays set.
- R6: toPulse is high for exactly one clock cycle per wrap.
- R7: While runEn is 0, the count and the prescaler are held at zero, minDone is 0, and sclEdge is ignored. After runEn rises with no sclEdge, the counter starts from 0, so minDone rises 48 cycles later.
- R8: An sclEdge that arrives before the minimum time has elapsed restarts both the count and the prescaler. Edges spaced closer than 6*n cycles therefore keep minDone at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclEdge | input | 1 | One-cycle strobe for an SCL transition |
| tSel | input | 2 | Timing select (cycle count n) |
| runEn | input | 1 | 1 runs the timer, 0 stops and clears it |
| ovfClr | input | 1 | Strobe that clears ovfFlag |
| minDone | output | 1 | Minimum SCL high/low time has elapsed |
| ovfFlag | output | 1 | Sticky bus-timeout flag |
| toPulse | output | 1 | One-cycle pulse when a timeout occurs |

## Verification
Two conflicts are provoked: a clear request landing on the wrap cycle, and an SCL edge landing on a prescaler tick. For the first, the bench waits out the full timeout for each timing select and asserts ovfClr in exactly the wrap cycle. The flag must survive that cycle and fall only on a later clear. The second conflict comes from random edge placement and from edge trains spaced tighter than the minimum time. Each edge must win, restarting the count so that minDone stays low. A cycle-level expectation model judges every cycle of the random run.

// File: rtl/sclt_pkg.sv
package sclt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic stop;   // hold count at zero
    logic load;   // reload with start value
    logic inc;    // advance one machine cycle
  } sclt_cmd_t;
endpackage

// File: rtl/sclt_dp.sv
module sclt_dp
  import sclt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_MARK = 8,
  parameter int CYC_BASE = 1,
  parameter int CYC_STEP = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  sclt_cmd_t  cmd,
  input  logic [1:0] tSel,
  output logic       atTop,
  output logic       preMark
);
  // one extra sign bit so start values below zero are legal
  localparam int DW = CNT_W + 1;
  localparam logic [DW-1:0] TOP_VAL  = {1'b0, {CNT_W{1'b1}}};
  localparam logic [DW-1:0] MARK_M1  = DW'(MIN_MARK - 1);

  logic [DW-1:0] cnt;
  logic [DW-1:0] loadVal;

  always_comb begin
    loadVal = DW'(MIN_MARK - CYC_BASE - CYC_STEP * int'(tSel));
  end

  assign atTop   = (cnt == TOP_VAL);
  assign preMark = (cnt == MARK_M1);

  always_ff @(posedge clk) begin
    if (!rstN)         cnt <= '0;
    else if (cmd.stop) cnt <= '0;
    else if (cmd.load) cnt <= loadVal;
    else if (cmd.inc)  cnt <= atTop ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sclt_ctrl.sv
module sclt_ctrl
  import sclt_pkg::*;
#(
  parameter int PRE_DIV = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclEdge,
  input  logic      runEn,
  input  logic      ovfClr,
  input  logic      atTop,
  input  logic      preMark,
  output sclt_cmd_t cmd,
  output logic      minDone,
  output logic      ovfFlag,
  output logic      toPulse
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] presc;
  logic          tick;
  logic          wrap;

  assign tick = (presc == PRE_LAST);

  always_comb begin
    cmd.stop = !runEn;
    cmd.load = runEn && sclEdge;
    cmd.inc  = runEn && !sclEdge && tick;
  end

  assign wrap = cmd.inc && atTop;

  // machine-cycle prescaler, restarted on each edge and while stopped
  always_ff @(posedge clk) begin
    if (!rstN)                     presc <= '0;
    else if (cmd.stop || cmd.load) presc <= '0;
    else                           presc <= tick ? '0 : presc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      minDone <= 1'b0;
      ovfFlag <= 1'b0;
      toPulse <= 1'b0;
    end else begin
      if (cmd.stop || cmd.load)   minDone <= 1'b0;
      else if (cmd.inc && preMark) minDone <= 1'b1;
      // a wrap wins over a clear in the same cycle
      if (wrap)        ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
      toPulse <= wrap;
    end
  end
endmodule

// File: rtl/sclt_timer.sv
module sclt_timer
  import sclt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_MARK = 8,
  parameter int CYC_BASE = 1,
  parameter int CYC_STEP = 3,
  parameter int PRE_DIV  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclEdge,
  input  logic [1:0] tSel,
  input  logic       runEn,
  input  logic       ovfClr,
  output logic       minDone,
  output logic       ovfFlag,
  output logic       toPulse
);
  sclt_cmd_t cmd;
  logic      atTop;
  logic      preMark;

  sclt_ctrl #(.PRE_DIV(PRE_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclEdge(sclEdge), .runEn(runEn),
    .ovfClr(ovfClr), .atTop(atTop), .preMark(preMark), .cmd(cmd),
    .minDone(minDone), .ovfFlag(ovfFlag), .toPulse(toPulse)
  );

  sclt_dp #(
    .CNT_W(CNT_W), .MIN_MARK(MIN_MARK),
    .CYC_BASE(CYC_BASE), .CYC_STEP(CYC_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .tSel(tSel),
    .atTop(atTop), .preMark(preMark)
  );
endmodule

// File: rtl/sclt_timer_chk.sv
module sclt_timer_chk (
  input logic clk,
  input logic rstN,
  input logic sclEdge,
  input logic runEn,
  input logic ovfClr,
  input logic minDone,
  input logic ovfFlag,
  input logic toPulse
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    toPulse |=> !toPulse); // R6
  AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    toPulse |-> ovfFlag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag); // R5
  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (sclEdge && runEn) |=> !minDone); // R2
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!minDone && !toPulse)); // R7
  AST_MIN_BEFORE_TO: assert property (@(posedge clk) disable iff (!rstN)
    toPulse |-> minDone); // R4
endmodule

bind sclt_timer sclt_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .sclEdge(sclEdge), .runEn(runEn),
  .ovfClr(ovfClr), .minDone(minDone), .ovfFlag(ovfFlag), .toPulse(toPulse)
);

// File: tb/tb_sclt_timer.sv
module tb_sclt_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, sclEdge, runEn, ovfClr;
  logic [1:0] tSel;
  logic minDone, ovfFlag, toPulse;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  // expectation state
  int mCnt, mPre;
  bit mMin, mOvf, mPulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclt_timer dut (
    .clk(clk), .rstN(rstN), .sclEdge(sclEdge), .tSel(tSel),
    .runEn(runEn), .ovfClr(ovfClr),
    .minDone(minDone), .ovfFlag(ovfFlag), .toPulse(toPulse)
  );

  function automatic int cycN(input int s);
    return 1 + 3 * s; // R3 encoding
  endfunction

  function automatic int toCycles(input int s);
    return 6 * (1016 + cycN(s)); // R4
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelUpdate(input bit e, input int s, input bit r, input bit c);
    bit wr;
    wr = 0;
    mPulse = 0;
    if (!r) begin
      mCnt = 0; mPre = 0; mMin = 0;
    end else if (e) begin
      mCnt = 8 - cycN(s); mPre = 0; mMin = 0;
    end else if (mPre == 5) begin
      mPre = 0;
      if (mCnt == 1023) begin mCnt = 0; wr = 1; end
      else begin mCnt++; if (mCnt == 8) mMin = 1; end
    end else begin
      mPre++;
    end
    if (wr) begin mOvf = 1; mPulse = 1; end
    else if (c) mOvf = 0;
  endtask

  task automatic step(input bit e, input int s, input bit r, input bit c);
    sclEdge = e; tSel = 2'(s); runEn = r; ovfClr = c;
    @(posedge clk);
    modelUpdate(e, s, r, c);
    #1;
    check("R2 minDone", int'(minDone), int'(mMin));
    check("R5 ovfFlag", int'(ovfFlag), int'(mOvf));
    check("R6 toPulse", int'(toPulse), int'(mPulse));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    int k;
    void'($urandom(32'd4711));
    rstN = 0; sclEdge = 0; tSel = 0; runEn = 0; ovfClr = 0;
    mCnt = 0; mPre = 0; mMin = 0; mOvf = 0; mPulse = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 minDone", int'(minDone), 0);
    check("R1 ovfFlag", int'(ovfFlag), 0);
    check("R1 toPulse", int'(toPulse), 0);
    rstN = 1;

    // R2 / R3: minimum time per select
    for (int s = 0; s < 4; s++) begin
      step(1, s, 1, 0);
      k = 0;
      while (!minDone && k < 200) begin step(0, s, 1, 0); k++; end
      check($sformatf("R2 R3 min cycles sel%0d", s), k, 6 * cycN(s));
    end

    // R8: edges every 5 cycles with n=1 never let minDone rise
    for (int j = 0; j < 10; j++) begin
      step(1, 0, 1, 0);
      repeat (4) step(0, 0, 1, 0);
      check("R8 early edge", int'(minDone), 0);
    end

    // R7: stopped timer ignores edges, restarts from zero
    for (int j = 0; j < 100; j++) step((j % 7) == 0, 3, 0, 0);
    check("R7 stopped minDone", int'(minDone), 0);
    k = 0;
    step(0, 3, 1, 0); k++;
    while (!minDone && k < 200) begin step(0, 3, 1, 0); k++; end
    check("R7 restart cycles", k, 48);

    // R4 / R5 / R6: timeout for every select
    for (int s = 0; s < 4; s++) begin
      step(1, s, 1, 0);
      for (int i = 1; i < toCycles(s); i++) step(0, s, 1, 0);
      check($sformatf("R4 no early timeout sel%0d", s), int'(ovfFlag), 0);
      step(0, s, 1, (s == 2)); // clear collides with wrap for sel 2
      check($sformatf("R4 pulse at wrap sel%0d", s), int'(toPulse), 1);
      check($sformatf("R5 flag set sel%0d", s), int'(ovfFlag), 1);
      step(0, s, 1, 0);
      check("R6 pulse width", int'(toPulse), 0);
      check("R5 sticky", int'(ovfFlag), 1);
      step(0, s, 1, 1);
      check("R5 cleared", int'(ovfFlag), 0);
    end

    // random mix judged by the expectation model
    for (int i = 0; i < 4000; i++) begin
      bit e, r, c;
      int s;
      e = ($urandom % 40) == 0;
      r = ($urandom % 100) != 0;
      c = ($urandom % 50) == 0;
      s = int'($urandom % 4);
      step(e, s, r, c);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule